// File: doc/BRIEF.md
# Supervised paired-column weight update driver

This block drives the programming phase of a resistive synapse array that has `ROWS` inputs and two columns per output neuron. Each neuron owns a positive column and a negative column. When an update is requested, the block takes the present input vector and a class label supplied by a supervisor. It then works out, for every row whose input bit is set, which columns must be strengthened and which weakened. The result depends only on the input bits and the label. The network's own answer plays no part.

Each column receives exactly one direction of change. The target neuron's positive column goes up and its negative column goes down. Every other neuron gets the opposite: positive column down, negative column up. The block issues the two directions one after the other. In the strengthen window, the selected rows are driven high and the strengthened columns are pulled low. In the weaken window, the selected rows are pulled low and the weakened columns are driven high. Lines with no role in a window are left floating. Each window lasts `PULSE_CYC` clocks, which is sized for the array's programming pulse width. Class label 0 maps to the last neuron, and label k maps to neuron k-1.

With training disabled, a request completes at once without driving anything. A label that names no neuron also completes at once, without drive, and sets an error flag.

Top module: `guide_update_driver`

## Requirements
- R1: Drive lane codes are 2 bits each: 00 float, 01 low, 10 high. Row r uses `row_drv_o[2r+1:2r]`. For neuron j (0-based), the positive column is lane 2j and the negative column is lane 2j+1 of `col_drv_o`, where lane c occupies bits [2c+1:2c].
- R2: Rows whose captured input bit is 0 stay at float for the whole update. Outside an update, every row and column lane is float.
- R3: Starting the cycle after an accepted training strobe with a valid label, for `PULSE_CYC` cycles: active rows are high; the target's positive column and every non-target's negative column are low; all other columns float.
- R4: For the next `PULSE_CYC` cycles: active rows are low; the target's negative column and every non-target's positive column are high; all other columns float.
- R5: Label 0 selects the last neuron (index `CLASSES-1`). Label k in 1..`CLASSES-1` selects neuron k-1.
- R6: A training strobe with a label of `CLASSES` or more drives nothing. It gives `done_o` the next cycle and sets `err_o`, which holds until the next accepted strobe.
- R7: A strobe with `train_en_i` low drives nothing, gives `done_o` the next cycle and clears `err_o`.
- R8: After a driven update, `done_o` pulses for one cycle, in the cycle after the last weaken cycle. That is the 2*`PULSE_CYC`-th cycle after the first strengthen cycle.
- R9: A strobe that arrives while an update is in progress is ignored. It changes neither the drive pattern nor the timing.
- R10: After reset, all lanes float and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| train_en_i | input | 1 | 1 = training, 0 = inference (no drive) |
| upd_stb_i | input | 1 | Update request strobe |
| in_vec_i | input | ROWS | Input bits, sampled on an accepted strobe |
| label_i | input | LBL_W | Supervisor class label |
| row_drv_o | output | 2*ROWS | Row drive codes |
| col_drv_o | output | 4*CLASSES | Column drive codes, two lanes per neuron |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Label out of range on last accepted strobe |

## Verification
The bench builds the block with 8 rows, 4 classes, a 3-bit label and 3-cycle windows. With a 3-bit label, the four out-of-range codes 4 to 7 can be reached next to all valid labels, including the wrap of label 0 onto the last neuron. The short windows let a full label sweep, a strobe during the busy period and back-to-back requests fit in a few hundred cycles. Eight rows are enough to apply all-zero, all-one and mixed input vectors, while a behavioural model predicts every lane on every clock.

// File: rtl/guide_pkg.sv
package guide_pkg;
  localparam logic [1:0] DRV_FLOAT = 2'b00;
  localparam logic [1:0] DRV_LOW   = 2'b01;
  localparam logic [1:0] DRV_HIGH  = 2'b10;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_INC  = 2'd1,
    PH_DEC  = 2'd2
  } phase_e;
endpackage

// File: rtl/guide_label_map.sv
module guide_label_map #(
  parameter int CLASSES = 10,
  parameter int LBL_W   = 4
) (
  input  logic [LBL_W-1:0]   label_i,
  output logic               valid_o,
  output logic [CLASSES-1:0] nrn_oh_o
);
  always_comb begin
    valid_o = (int'(label_i) < CLASSES);
    for (int k = 0; k < CLASSES; k++) begin
      if (k == CLASSES - 1)
        nrn_oh_o[k] = valid_o && (int'(label_i) == 0);
      else
        nrn_oh_o[k] = valid_o && (int'(label_i) == k + 1);
    end
  end
endmodule

// File: rtl/guide_col_plan.sv
module guide_col_plan #(
  parameter int CLASSES = 10,
  localparam int COLS = 2 * CLASSES
) (
  input  logic [CLASSES-1:0] nrn_oh_i,
  output logic [COLS-1:0]    inc_mask_o
);
  for (genvar j = 0; j < CLASSES; j++) begin : g_pair
    assign inc_mask_o[2*j]   = nrn_oh_i[j];
    assign inc_mask_o[2*j+1] = ~nrn_oh_i[j];
  end

  always_comb begin
    assert_target_onehot_R1: assert ($onehot0(nrn_oh_i));
  end
endmodule

// File: rtl/guide_phase_timer.sv
module guide_phase_timer
  import guide_pkg::*;
#(
  parameter int PULSE_CYC = 38,
  localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic sw_o,
  output logic fin_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last   = (int'(cnt_q) == PULSE_CYC - 1);
  assign busy_o = (phase_q != PH_IDLE);
  assign sw_o   = (phase_q == PH_INC) && last;
  assign fin_o  = (phase_q == PH_DEC) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_INC;
          cnt_q   <= '0;
        end
        PH_INC: if (last) begin
          phase_q <= PH_DEC;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        PH_DEC: if (last) begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assert_dec_follows_inc_R4: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INC && last) |=> (phase_q == PH_DEC));
  assert_idle_after_dec_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DEC && last) |=> (phase_q == PH_IDLE));
endmodule

// File: rtl/guide_update_driver.sv
module guide_update_driver
  import guide_pkg::*;
#(
  parameter int ROWS      = 100,
  parameter int CLASSES   = 10,
  parameter int LBL_W     = 4,
  parameter int PULSE_CYC = 38,
  localparam int COLS = 2 * CLASSES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              train_en_i,
  input  logic              upd_stb_i,
  input  logic [ROWS-1:0]   in_vec_i,
  input  logic [LBL_W-1:0]  label_i,
  output logic [2*ROWS-1:0] row_drv_o,
  output logic [2*COLS-1:0] col_drv_o,
  output logic              done_o,
  output logic              err_o
);
  logic               lbl_ok;
  logic [CLASSES-1:0] nrn_oh;
  logic [COLS-1:0]    inc_mask;
  logic [ROWS-1:0]    vec_q;
  logic [COLS-1:0]    inc_q;
  logic               busy, sw, fin, accept, start;
  logic [2*ROWS-1:0]  row_nxt;
  logic [2*COLS-1:0]  col_nxt;

  guide_label_map #(.CLASSES(CLASSES), .LBL_W(LBL_W)) u_map (
    .label_i(label_i), .valid_o(lbl_ok), .nrn_oh_o(nrn_oh));

  guide_col_plan #(.CLASSES(CLASSES)) u_plan (
    .nrn_oh_i(nrn_oh), .inc_mask_o(inc_mask));

  guide_phase_timer #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk(clk), .rst(rst), .start_i(start),
    .busy_o(busy), .sw_o(sw), .fin_o(fin));

  assign accept = upd_stb_i && !busy;
  assign start  = accept && train_en_i && lbl_ok;

  always_comb begin
    row_nxt = row_drv_o;
    col_nxt = col_drv_o;
    if (start) begin
      for (int r = 0; r < ROWS; r++)
        row_nxt[2*r +: 2] = in_vec_i[r] ? DRV_HIGH : DRV_FLOAT;
      for (int c = 0; c < COLS; c++)
        col_nxt[2*c +: 2] = inc_mask[c] ? DRV_LOW : DRV_FLOAT;
    end else if (sw) begin
      for (int r = 0; r < ROWS; r++)
        row_nxt[2*r +: 2] = vec_q[r] ? DRV_LOW : DRV_FLOAT;
      for (int c = 0; c < COLS; c++)
        col_nxt[2*c +: 2] = inc_q[c] ? DRV_FLOAT : DRV_HIGH;
    end else if (fin) begin
      row_nxt = '0;
      col_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_drv_o <= '0;
      col_drv_o <= '0;
      vec_q     <= '0;
      inc_q     <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      row_drv_o <= row_nxt;
      col_drv_o <= col_nxt;
      done_o    <= fin || (accept && !start);
      if (accept) err_o <= train_en_i && !lbl_ok;
      if (start) begin
        vec_q <= in_vec_i;
        inc_q <= inc_mask;
      end
    end
  end

  assert_train_off_R7: assert property (@(posedge clk) disable iff (rst)
    (upd_stb_i && !busy && !train_en_i) |=> (done_o && !err_o && row_drv_o == '0));
  assert_bad_label_R6: assert property (@(posedge clk) disable iff (rst)
    (upd_stb_i && !busy && train_en_i && !lbl_ok) |=> (done_o && err_o && col_drv_o == '0));
  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && upd_stb_i && !fin) |=> ($stable(vec_q) && $stable(inc_q)));
  assert_done_after_fin_R8: assert property (@(posedge clk) disable iff (rst)
    fin |=> (done_o && row_drv_o == '0));
endmodule

// File: tb/guide_update_driver_tb.sv
module guide_update_driver_tb_top;
  localparam int ROWS = 8;
  localparam int CLASSES = 4;
  localparam int LBL_W = 3;
  localparam int P = 3;
  localparam int COLS = 2 * CLASSES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic train_en = 1'b1;
  logic stb = 1'b0;
  logic [ROWS-1:0] vec = '0;
  logic [LBL_W-1:0] lbl = '0;
  logic [2*ROWS-1:0] row_drv;
  logic [2*COLS-1:0] col_drv;
  logic done, err;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  guide_update_driver #(.ROWS(ROWS), .CLASSES(CLASSES), .LBL_W(LBL_W), .PULSE_CYC(P)) dut_i (
    .clk(clk), .rst(rst), .train_en_i(train_en), .upd_stb_i(stb), .in_vec_i(vec),
    .label_i(lbl), .row_drv_o(row_drv), .col_drv_o(col_drv), .done_o(done), .err_o(err));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_phase = 0, m_cnt = 0, m_nrn = 0;
  logic [ROWS-1:0] m_vec = '0;
  logic [2*ROWS-1:0] e_row = '0;
  logic [2*COLS-1:0] e_col = '0;
  logic e_done = 0, e_err = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_cnt = 0; e_done = 0; e_err = 0;
    end else begin
      e_done = 0;
      if (m_phase == 0) begin
        if (stb) begin
          if (!train_en) begin e_done = 1; e_err = 0; end
          else if (int'(lbl) >= CLASSES) begin e_done = 1; e_err = 1; end
          else begin
            e_err = 0; m_vec = vec;
            m_nrn = (lbl == 0) ? CLASSES - 1 : int'(lbl) - 1;
            m_phase = 1; m_cnt = 0;
          end
        end
      end else begin
        m_cnt++;
        if (m_cnt == P) begin
          m_cnt = 0;
          if (m_phase == 1) m_phase = 2;
          else begin m_phase = 0; e_done = 1; end
        end
      end
    end
    e_row = '0; e_col = '0;
    if (m_phase != 0) begin
      for (int r = 0; r < ROWS; r++)
        if (m_vec[r]) e_row[2*r +: 2] = (m_phase == 1) ? 2'b10 : 2'b01;
      for (int c = 0; c < COLS; c++) begin
        bit up;
        up = ((c % 2) == 0) ? (c / 2 == m_nrn) : (c / 2 != m_nrn);
        if (m_phase == 1 && up) e_col[2*c +: 2] = 2'b01;
        if (m_phase == 2 && !up) e_col[2*c +: 2] = 2'b10;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check("R2 rows", 32'(row_drv), 32'(e_row));
      check(m_phase == 1 ? "R3 cols" : m_phase == 2 ? "R4 cols" : "R2 idle cols",
            32'(col_drv), 32'(e_col));
      check("R8 done", 32'(done), 32'(e_done));
      check("R6 err", 32'(err), 32'(e_err));
    end
  end

  // Drive one strobe; returns at the negedge after the accepting edge
  task automatic strobe(logic ten, logic [LBL_W-1:0] l, logic [ROWS-1:0] v);
    @(negedge clk);
    train_en = ten; lbl = l; vec = v; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int k;
    logic [2*COLS-1:0] first_col;
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    check("R10 rows", 32'(row_drv), 32'h0);
    check("R10 cols", 32'(col_drv), 32'h0);
    check("R10 done/err", {30'd0, done, err}, 32'h0);

    strobe(1, 3'd1, 8'hA5);
    check("R1 neuron0 strengthen lanes", 32'(col_drv), 32'h4441);
    k = 0;
    while (!done && k < 20) begin @(negedge clk); k++; end
    check("R8 done latency", 32'(k), 32'(2 * P));

    strobe(1, 3'd0, 8'h3C);
    check("R5 label0 to last neuron", 32'(col_drv), 32'h1444);
    idle(2 * P + 1);

    strobe(1, 3'd2, 8'h00);
    check("R2 zero vector rows float", 32'(row_drv), 32'h0);
    idle(2 * P + 1);

    strobe(1, 3'd5, 8'hFF);
    check("R6 done on bad label", 32'(done), 32'h1);
    check("R6 err set", 32'(err), 32'h1);
    check("R6 no row drive", 32'(row_drv), 32'h0);
    idle(3);
    check("R6 err held", 32'(err), 32'h1);

    strobe(0, 3'd2, 8'hFF);
    check("R7 done immediate", 32'(done), 32'h1);
    check("R7 err cleared", 32'(err), 32'h0);
    check("R7 no drive", 32'(row_drv | col_drv), 32'h0);
    idle(2);

    strobe(1, 3'd2, 8'hFF);
    first_col = col_drv;
    stb = 1'b1; lbl = 3'd1; vec = 8'h0F;
    @(negedge clk);
    stb = 1'b0;
    check("R9 busy strobe ignored", 32'(col_drv), 32'(first_col));
    idle(2 * P + 2);

    for (int l = 0; l < 8; l++) begin
      strobe(1, 3'(l), 8'(8'h5A ^ (l * 37)));
      idle(2 * P + 1);
    end
    strobe(1, 3'd3, 8'h81);
    idle(2 * P - 1);
    strobe(1, 3'd4, 8'h7E);
    strobe(1, 3'd2, 8'hC3);
    idle(2 * P + 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule